// File: doc/BRIEF.md
# USB Pipe Data Toggle Tracker

This block keeps the DATA0/DATA1 sequence bit for every pipe of a USB function or host controller, pipe 0 being the default control pipe. The packet engine reports one handshake event per cycle at most, giving the pipe, the data direction, the handshake seen or sent on the wire and a CRC error flag for received data. The tracker flips the pipe's bit only when that event means the data packet was accepted by both sides. The current bits drive the expected PID for reception and the PID used for transmission, and they also serve as the status view software reads.

Software may force any pipe to DATA0 or DATA1 with per-pipe strobes. While the controller runs as a peripheral, the control pipe follows the control-transfer stage rules by itself: it goes to DATA0 when a setup stage ends and to DATA1 when the status stage begins. While it runs as a host, stage strobes are ignored and software programs the bit. Isochronous pipes exchange no ACK, so they never flip on handshakes, and the set strobe does nothing on them.

Top module: `usb_toggle_tracker`

## Requirements
- R1: After reset every bit of `pid_o` is 0 (DATA0).
- R2: An event with `evt_dir_tx_i`=1 and `evt_hs_i`=2'b01 (ACK received) inverts the bit of pipe `evt_pipe_i` one cycle later; `evt_crc_err_i` has no effect on transmit events.
- R3: An event with `evt_dir_tx_i`=0, `evt_hs_i`=2'b01 (ACK sent) and `evt_crc_err_i`=0 inverts the bit of that pipe one cycle later.
- R4: Events with `evt_hs_i` of 2'b00 (no handshake), 2'b10 (NAK) or 2'b11 (STALL), and receive events with `evt_crc_err_i`=1, leave every bit unchanged.
- R5: `sw_clr_i[n]`=1 makes bit n 0 on the next cycle.
- R6: `sw_set_i[n]`=1 makes bit n 1 on the next cycle; when `sw_clr_i[n]` is also 1, the bit becomes 0.
- R7: For a pipe whose `iso_map_i` bit is 1, `sw_set_i` and ACK events leave its bit unchanged; `sw_clr_i` still clears it.
- R8: With `host_mode_i`=0, `setup_done_i`=1 makes bit 0 become 0 on the next cycle.
- R9: With `host_mode_i`=0, `status_stage_i`=1 makes bit 0 become 1 on the next cycle.
- R10: With `host_mode_i`=1, `setup_done_i` and `status_stage_i` have no effect on bit 0.
- R11: Per pipe, the priority is clear strobe, then set strobe, then setup-done, then status-stage, then the handshake toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_mode_i | input | 1 | 1 = host role, 0 = peripheral role |
| iso_map_i | input | NUM_PIPES | Per-pipe flag, 1 = isochronous transfer type |
| evt_valid_i | input | 1 | Handshake event present this cycle |
| evt_pipe_i | input | PIPE_W | Pipe index of the event |
| evt_dir_tx_i | input | 1 | 1 = pipe sent data, 0 = pipe received data |
| evt_hs_i | input | 2 | Handshake: 00 none, 01 ACK, 10 NAK, 11 STALL |
| evt_crc_err_i | input | 1 | Received data had a CRC error |
| setup_done_i | input | 1 | Control setup stage completed |
| status_stage_i | input | 1 | Control status stage entered |
| sw_clr_i | input | NUM_PIPES | Per-pipe force to DATA0 |
| sw_set_i | input | NUM_PIPES | Per-pipe force to DATA1 |
| pid_o | output | NUM_PIPES | Current sequence bit per pipe (0 = DATA0) |

## Verification
A wrong bit inside this block is the value on `pid_o` itself, so any corrupted toggle, missed force or wrong priority shows on the port one cycle after the offending event, and it stays wrong until a later command overwrites it. The bench therefore compares all pipe bits every cycle against a reference model under random events, strobes and mode changes, and adds directed cases for the ACK qualifiers, the isochronous exemptions, the stage forces in both roles and every priority collision.

// File: rtl/usb_tgl_pkg.sv
package usb_tgl_pkg;
  typedef enum logic [1:0] {
    HS_NONE  = 2'b00,
    HS_ACK   = 2'b01,
    HS_NAK   = 2'b10,
    HS_STALL = 2'b11
  } hs_e;

  localparam int unsigned CTRL_PIPE = 0;
endpackage

// File: rtl/usb_tgl_evt_dec.sv
module usb_tgl_evt_dec
  import usb_tgl_pkg::*;
#(
  parameter int unsigned NUM_PIPES = 8,
  parameter int unsigned PIPE_W    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [PIPE_W-1:0]    pipe_i,
  input  logic                 dir_tx_i,
  input  logic [1:0]           hs_i,
  input  logic                 crc_err_i,
  input  logic [NUM_PIPES-1:0] iso_map_i,
  output logic [NUM_PIPES-1:0] tgl_o
);
  hs_e  hs;
  logic accepted;

  assign hs = hs_e'(hs_i);
  // tx: ACK came back; rx: ACK went out, only for clean data
  assign accepted = valid_i && (hs == HS_ACK) && (dir_tx_i || !crc_err_i);

  always_comb begin
    tgl_o = '0;
    for (int i = 0; i < NUM_PIPES; i++) begin
      if (accepted && (pipe_i == PIPE_W'(i)) && !iso_map_i[i]) tgl_o[i] = 1'b1;
    end
  end

  // R2
  tgl_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tgl_o));

  // R7
  tgl_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgl_o & iso_map_i) == '0);
endmodule

// File: rtl/usb_tgl_ctrl_stage.sv
module usb_tgl_ctrl_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic host_mode_i,
  input  logic setup_done_i,
  input  logic status_stage_i,
  output logic force_clr_o,
  output logic force_set_o
);
  // peripheral role only; setup end outranks status entry
  assign force_clr_o = !host_mode_i && setup_done_i;
  assign force_set_o = !host_mode_i && status_stage_i && !setup_done_i;

  // R11
  force_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(force_clr_o && force_set_o));
endmodule

// File: rtl/usb_tgl_bit.sv
module usb_tgl_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic set_i,
  input  logic iso_i,
  input  logic force_clr_i,
  input  logic force_set_i,
  input  logic tgl_i,
  output logic q_o
);
  logic set_eff;
  logic q_d;

  assign set_eff = set_i && !iso_i;

  always_comb begin
    if (clr_i)            q_d = 1'b0;
    else if (set_eff)     q_d = 1'b1;
    else if (force_clr_i) q_d = 1'b0;
    else if (force_set_i) q_d = 1'b1;
    else if (tgl_i)       q_d = !q_o;
    else                  q_d = q_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= q_d;
  end

  // R5
  clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !q_o);

  // R6
  set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !iso_i && !clr_i) |=> q_o);

  // R7
  iso_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iso_i && !clr_i && !force_clr_i && !force_set_i && !tgl_i) |=> $stable(q_o));

  // R2
  flip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgl_i && !clr_i && !set_i && !force_clr_i && !force_set_i) |=> (q_o != $past(q_o)));
endmodule

// File: rtl/usb_toggle_tracker.sv
module usb_toggle_tracker
  import usb_tgl_pkg::*;
#(
  parameter int unsigned NUM_PIPES = 8,
  localparam int unsigned PIPE_W   = (NUM_PIPES > 1) ? $clog2(NUM_PIPES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 host_mode_i,
  input  logic [NUM_PIPES-1:0] iso_map_i,
  input  logic                 evt_valid_i,
  input  logic [PIPE_W-1:0]    evt_pipe_i,
  input  logic                 evt_dir_tx_i,
  input  logic [1:0]           evt_hs_i,
  input  logic                 evt_crc_err_i,
  input  logic                 setup_done_i,
  input  logic                 status_stage_i,
  input  logic [NUM_PIPES-1:0] sw_clr_i,
  input  logic [NUM_PIPES-1:0] sw_set_i,
  output logic [NUM_PIPES-1:0] pid_o
);
  logic [NUM_PIPES-1:0] tgl;
  logic                 stg_clr;
  logic                 stg_set;

  usb_tgl_evt_dec #(
    .NUM_PIPES(NUM_PIPES),
    .PIPE_W   (PIPE_W)
  ) u_evt_dec (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (evt_valid_i),
    .pipe_i   (evt_pipe_i),
    .dir_tx_i (evt_dir_tx_i),
    .hs_i     (evt_hs_i),
    .crc_err_i(evt_crc_err_i),
    .iso_map_i(iso_map_i),
    .tgl_o    (tgl)
  );

  usb_tgl_ctrl_stage u_ctrl_stage (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .host_mode_i   (host_mode_i),
    .setup_done_i  (setup_done_i),
    .status_stage_i(status_stage_i),
    .force_clr_o   (stg_clr),
    .force_set_o   (stg_set)
  );

  for (genvar g = 0; g < NUM_PIPES; g++) begin : g_pipe
    logic fclr;
    logic fset;
    if (g == CTRL_PIPE) begin : g_ctrl
      assign fclr = stg_clr;
      assign fset = stg_set;
    end else begin : g_data
      assign fclr = 1'b0;
      assign fset = 1'b0;
    end

    usb_tgl_bit u_bit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (sw_clr_i[g]),
      .set_i      (sw_set_i[g]),
      .iso_i      (iso_map_i[g]),
      .force_clr_i(fclr),
      .force_set_i(fset),
      .tgl_i      (tgl[g]),
      .q_o        (pid_o[g])
    );
  end

  // R4
  no_hs_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_valid_i && evt_hs_i != 2'b01 && sw_clr_i == '0 && sw_set_i == '0
     && !setup_done_i && !status_stage_i) |=> $stable(pid_o));

  // R10
  host_stage_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_mode_i && !sw_clr_i[0] && !sw_set_i[0]
     && !(evt_valid_i && evt_pipe_i == '0 && evt_hs_i == 2'b01)) |=> $stable(pid_o[0]));

  // R8
  setup_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_mode_i && setup_done_i && !sw_set_i[0]) |=> !pid_o[0]);

  // R9
  status_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_mode_i && status_stage_i && !setup_done_i && !sw_clr_i[0]) |=> pid_o[0]);
endmodule

// File: tb/usb_toggle_tracker_tb_top.sv
module usb_toggle_tracker_tb_top;
  localparam int unsigned NP         = 8;
  localparam int unsigned PW         = 3;
  localparam time         CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_mode;
  logic [NP-1:0] iso_map;
  logic          evt_valid;
  logic [PW-1:0] evt_pipe;
  logic          evt_dir_tx;
  logic [1:0]    evt_hs;
  logic          evt_crc_err;
  logic          setup_done;
  logic          status_stage;
  logic [NP-1:0] sw_clr;
  logic [NP-1:0] sw_set;
  logic [NP-1:0] pid;

  logic [NP-1:0] exp_pid;
  int            n_run = 0;
  int            n_fail = 0;
  bit            done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_toggle_tracker #(.NUM_PIPES(NP)) dut_i (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .host_mode_i   (host_mode),
    .iso_map_i     (iso_map),
    .evt_valid_i   (evt_valid),
    .evt_pipe_i    (evt_pipe),
    .evt_dir_tx_i  (evt_dir_tx),
    .evt_hs_i      (evt_hs),
    .evt_crc_err_i (evt_crc_err),
    .setup_done_i  (setup_done),
    .status_stage_i(status_stage),
    .sw_clr_i      (sw_clr),
    .sw_set_i      (sw_set),
    .pid_o         (pid)
  );

  // reference: next bits from current bits and the driven inputs
  function automatic logic [NP-1:0] next_pid(input logic [NP-1:0] cur);
    logic [NP-1:0] n;
    logic          acc;
    n   = cur;
    acc = evt_valid && evt_hs == 2'b01 && (evt_dir_tx || !evt_crc_err);
    for (int i = 0; i < NP; i++) begin
      if (sw_clr[i])                              n[i] = 1'b0;
      else if (sw_set[i] && !iso_map[i])          n[i] = 1'b1;
      else if (i == 0 && !host_mode && setup_done)   n[i] = 1'b0;
      else if (i == 0 && !host_mode && status_stage) n[i] = 1'b1;
      else if (acc && evt_pipe == PW'(i) && !iso_map[i]) n[i] = !cur[i];
    end
    return n;
  endfunction

  task automatic idle();
    evt_valid = 0; evt_pipe = '0; evt_dir_tx = 0; evt_hs = 2'b00; evt_crc_err = 0;
    setup_done = 0; status_stage = 0; sw_clr = '0; sw_set = '0;
  endtask

  task automatic tick();
    exp_pid = next_pid(exp_pid);
    @(negedge clk);
    idle();
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    n_run++;
    if (pid !== exp_pid) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, pid, exp_pid);
    end
  endtask

  task automatic ev(input int p, input bit tx, input logic [1:0] hs, input bit crc);
    evt_valid = 1; evt_pipe = PW'(p); evt_dir_tx = tx; evt_hs = hs; evt_crc_err = crc;
    tick();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    host_mode = 0;
    iso_map = 8'b1000_0000;
    idle();
    exp_pid = '0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1;
    chk("R1 reset", pid == '0, 1'b1);

    ev(3, 1, 2'b01, 0);  chk("R2 tx ACK", pid[3], 1'b1);
    ev(3, 1, 2'b01, 0);  chk("R2 tx ACK again", pid[3], 1'b0);
    ev(2, 0, 2'b01, 0);  chk("R3 rx ACK", pid[2], 1'b1);
    ev(2, 0, 2'b01, 1);  chk("R4 rx crc err", pid[2], 1'b1);
    ev(4, 1, 2'b01, 1);  chk("R2 tx ignores crc", pid[4], 1'b1);
    ev(2, 0, 2'b10, 0);  chk("R4 NAK", pid[2], 1'b1);
    ev(2, 1, 2'b11, 0);  chk("R4 STALL", pid[2], 1'b1);
    ev(2, 1, 2'b00, 0);  chk("R4 none", pid[2], 1'b1);

    sw_clr[2] = 1; tick(); chk("R5 clear", pid[2], 1'b0);
    sw_set[5] = 1; tick(); chk("R6 set", pid[5], 1'b1);
    sw_set[6] = 1; sw_clr[6] = 1; tick(); chk("R6 clr wins", pid[6], 1'b0);
    sw_clr[5] = 1; sw_set[5] = 1; tick(); chk("R6 clr wins on 1", pid[5], 1'b0);

    sw_set[7] = 1; tick(); chk("R7 iso set ignored", pid[7], 1'b0);
    ev(7, 1, 2'b01, 0);  chk("R7 iso ACK ignored", pid[7], 1'b0);

    sw_set[0] = 1; tick(); chk("R6 set pipe0", pid[0], 1'b1);
    setup_done = 1; tick(); chk("R8 setup to DATA0", pid[0], 1'b0);
    status_stage = 1; tick(); chk("R9 status to DATA1", pid[0], 1'b1);
    setup_done = 1; status_stage = 1; tick(); chk("R11 setup over status", pid[0], 1'b0);

    host_mode = 1;
    status_stage = 1; tick(); chk("R10 host status ignored", pid[0], 1'b0);
    sw_set[0] = 1; tick();
    setup_done = 1; tick(); chk("R10 host setup ignored", pid[0], 1'b1);
    host_mode = 0;

    status_stage = 1; sw_clr[0] = 1; tick(); chk("R11 clr over status", pid[0], 1'b0);
    setup_done = 1; sw_set[0] = 1; tick(); chk("R11 set over setup", pid[0], 1'b1);
    status_stage = 1; evt_valid = 1; evt_pipe = '0; evt_dir_tx = 1; evt_hs = 2'b01;
    tick(); chk("R11 status over toggle", pid[0], 1'b1);
    chk_all("R1 model sync");

    // random phase
    for (int k = 0; k < 3000; k++) begin
      if (k % 250 == 0) begin
        iso_map   = NP'($urandom);
        host_mode = $urandom_range(0, 1) == 1;
      end
      evt_valid   = $urandom_range(0, 9) < 7;
      evt_pipe    = PW'($urandom);
      evt_dir_tx  = $urandom_range(0, 1) == 1;
      evt_hs      = 2'($urandom);
      evt_crc_err = $urandom_range(0, 3) == 0;
      setup_done  = $urandom_range(0, 9) == 0;
      status_stage = $urandom_range(0, 9) == 0;
      for (int i = 0; i < NP; i++) begin
        sw_clr[i] = $urandom_range(0, 15) == 0;
        sw_set[i] = $urandom_range(0, 15) == 0;
      end
      tick();
      chk_all("random R11 model");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule